// File: doc/BRIEF.md
# Serial Soft-Decision Viterbi Decoder

This block decodes a rate-1/N convolutional code. It accepts soft symbols and produces hard decoded bits. It has a single add-compare-select path that is time-shared over the trellis. Each accepted load brings in one group of N soft symbols. The block then spends exactly 2^(L-1) enabled cycles on that group, one cycle per trellis state. In each cycle it reads the two predecessor path metrics from a metric bank, adds the branch metrics, keeps the larger sum and records which predecessor won.

Path metrics sit in two banks that swap roles after each group: one bank is read while the other is written. The one-bit survivor decisions go into a ring of V+1 columns. While the current group is swept, a traceback engine walks V columns back from the best state of the previous group and releases one decoded bit. Metrics are unsigned and grow without bound, so they are kept in range by halving. If any metric written during a group has its top bit set, every metric is halved as it is read during the next group, and a one-clock normalize pulse is given.

The controller has two states. IDLE waits for a group. SWEEP visits the states, counting from 0 to 2^(L-1)-1. The transitions are:
- IDLE to SWEEP on an accepted load.
- SWEEP to SWEEP when the last count coincides with a load, so groups run back to back.
- SWEEP to IDLE when the last count has no load.
- Any state holds while the enable input is low.

Top module: `vit_serial_decoder`

## Requirements
- R1: The input `rr` carries N fields of SB bits. The first-received symbol is in `rr[N*SB-1 -: SB]` and the last-received symbol is in the least significant field. Field i is checked against generator POLYi.
- R2: Each soft value is two's complement, with these meanings:
  - A negative value means a coded 1.
  - A positive value means a coded 0.
  - Zero means an erased symbol.

  Coded bit i is the XOR of (window AND POLYi). Window bit 0 is the newest input bit, and bit k is the input k steps earlier. The encoder starts from all zeros. A noiseless stream of strongest values (+3 for 0, -3 for 1 at SB=3) decodes without error. This also holds when some symbols are replaced by zero.
- R3: Reset clears every path metric. When a metric written during a group has its top bit set, all metrics are halved for the next group. The normalize output is then high for exactly one clock, and decoding stays error-free across the event.
- R4: An accepted group takes exactly 2^(L-1) enabled cycles. With back-to-back loads, outvalid pulses once every 2^(L-1) clocks. Each pulse lasts one clock and carries ceil(V/2^(L-1)) decoded bits, which is one bit by default.
- R5: The bit of group g is released during the sweep of group g+V+1. The first outvalid therefore falls in the sweep of the (V+2)-th accepted group. Bits leave in input order. After the final sweep the number of outputs equals the number of groups minus V minus 1.
- R6: ready is high in IDLE and in the last cycle of a sweep, and low in every other cycle. A group is taken only at an edge where enable, load and ready are all high. A load at any other edge has no effect on the decoded output.
- R7: While enable is low, nothing advances. No outvalid or normalize pulse is produced from an edge sampled with enable low, and the decoded bits are not affected by the stall.
- R8: After reset, ready is 1, and outvalid, normalize and decbits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| enable | input | 1 | Low freezes all processing |
| load | input | 1 | Strobe that takes the symbol group when ready is high |
| rr | input | N*SB | Packed group of soft symbols, first-received symbol in the MSBs |
| ready | output | 1 | A group will be taken at the next rising edge if load is high |
| decbits | output | OUTW | Decoded bit(s) |
| outvalid | output | 1 | One-clock pulse marking valid decbits |
| normalize | output | 1 | One-clock pulse marking a metric halving |

## Verification
The hardest condition to reach from the ports is metric normalization. It happens only after the best path metric has climbed to the top bit. With noiseless input the metric gains at most 14 per group, so that takes several hundred groups. The stimulus therefore runs about 800 groups of random data, and checks every decoded bit across the halving event. Stalls are placed so that they straddle the traceback output cycle, and ignored loads are placed in mid-sweep. A long run of groups with one symbol erased in every third group exercises the zero-symbol path.

// File: rtl/vit_pkg.sv
package vit_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } vit_state_e;

endpackage

// File: rtl/vit_branch.sv
module vit_branch #(
    parameter int N   = 2,
    parameter int L   = 7,
    parameter int SB  = 3,
    parameter int BMW = 5,
    parameter logic [N-1:0][L-1:0] TAPS = '0
) (
    input  logic [N*SB-1:0] sym,
    input  logic [L-1:0]    win,
    output logic [BMW-1:0]  bm
);

    localparam int BIAS = 1 << (SB - 1);

    always_comb begin
        int acc;
        acc = 0;
        for (int i = 0; i < N; i++) begin
            logic signed [SB-1:0] r;
            r = $signed(sym[(N-i)*SB-1 -: SB]);
            if (^(win & TAPS[i])) begin
                acc = acc + BIAS - int'(r);
            end else begin
                acc = acc + BIAS + int'(r);
            end
        end
        bm = BMW'(acc);
    end

endmodule

// File: rtl/vit_metric_store.sv
module vit_metric_store #(
    parameter int S  = 64,
    parameter int SW = 6,
    parameter int MW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          bank,
    input  logic          halve,
    input  logic [SW-1:0] rd_a,
    input  logic [SW-1:0] rd_b,
    input  logic [SW-1:0] wr_addr,
    input  logic [MW-1:0] wr_data,
    output logic [MW-1:0] m_a,
    output logic [MW-1:0] m_b
);

    logic [1:0][S-1:0][MW-1:0] mem;
    logic [MW-1:0] raw_a, raw_b;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[~bank][wr_addr] <= wr_data;
        end
    end

    assign raw_a = mem[bank][rd_a];
    assign raw_b = mem[bank][rd_b];
    assign m_a   = halve ? {1'b0, raw_a[MW-1:1]} : raw_a;
    assign m_b   = halve ? {1'b0, raw_b[MW-1:1]} : raw_b;

endmodule

// File: rtl/vit_traceback.sv
module vit_traceback #(
    parameter int S  = 64,
    parameter int SW = 6,
    parameter int D  = 36,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_col,
    input  logic [SW-1:0] wr_state,
    input  logic          wr_dec,
    input  logic          tb_load,
    input  logic [CW-1:0] tb_col0,
    input  logic [SW-1:0] tb_state0,
    input  logic          tb_step,
    output logic          tb_bit
);

    logic [D-1:0][S-1:0] surv;
    logic [SW-1:0]       st_q;
    logic [CW-1:0]       col_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            surv  <= '0;
            st_q  <= '0;
            col_q <= '0;
        end else begin
            if (wr_en) begin
                surv[wr_col][wr_state] <= wr_dec;
            end
            if (tb_load) begin
                st_q  <= tb_state0;
                col_q <= tb_col0;
            end else if (tb_step) begin
                st_q  <= {surv[col_q][st_q], st_q[SW-1:1]};
                col_q <= (col_q == '0) ? CW'(D - 1) : col_q - CW'(1);
            end
        end
    end

    assign tb_bit = st_q[0];

    AST_TB_COL_FREE: assert property (@(posedge clk) disable iff (rst)
        (tb_step && wr_en) |-> (col_q != wr_col)); // R5

endmodule

// File: rtl/vit_serial_decoder.sv
module vit_serial_decoder
    import vit_pkg::*;
#(
    parameter int N     = 2,
    parameter int L     = 7,
    parameter int SB    = 3,
    parameter int MW    = 14,
    parameter int V     = 35,
    parameter int POLY0 = 91,
    parameter int POLY1 = 121,
    parameter int POLY2 = 0,
    parameter int POLY3 = 0,
    parameter int POLY4 = 0,
    parameter int POLY5 = 0,
    parameter int POLY6 = 0,
    parameter int S     = 1 << (L - 1),
    parameter int OUTW  = (V + S - 1) / S
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            load,
    input  logic [N*SB-1:0] rr,
    output logic            ready,
    output logic [OUTW-1:0] decbits,
    output logic            outvalid,
    output logic            normalize
);

    localparam int SW  = L - 1;
    localparam int D   = V + 1;
    localparam int CW  = $clog2(D);
    localparam int DW  = $clog2(D + 1);
    localparam int BMW = $clog2(N * (1 << SB) + 1);
    localparam logic [SW-1:0] LAST    = SW'(S - 1);
    localparam logic [SW-1:0] TB_LAST = SW'(V);
    localparam logic [SW-1:0] TB_OUT  = SW'(V + 1);
    localparam logic [6:0][L-1:0] ALL_TAPS = {L'(POLY6), L'(POLY5), L'(POLY4),
        L'(POLY3), L'(POLY2), L'(POLY1), L'(POLY0)};
    localparam logic [N-1:0][L-1:0] TAPS = ALL_TAPS[N-1:0];

    vit_state_e      state_q, state_d;
    logic [SW-1:0]   cnt_q, cnt_d;
    logic [N*SB-1:0] sym_q;
    logic [CW-1:0]   wcol_q, tb_col0;
    logic            bank_q, halve_q, nflag_q;
    logic [DW-1:0]   done_q;
    logic [SW-1:0]   best_q, run_s_q, best_all;
    logic [MW-1:0]   run_m_q;
    logic [OUTW-1:0] decbits_q;
    logic            outvalid_q, normalize_q;
    logic            sweeping, at_last, accept, acs_en;
    logic [SW-1:0]   pred_a, pred_b;
    logic [MW-1:0]   m_a, m_b, new_m;
    logic [BMW-1:0]  bm [2];
    logic [MW:0]     sum_a, sum_b, sel_sum;
    logic            pick, better, nflag_all;
    logic            tb_load, tb_step, tb_bit;

    // ---------------- control ----------------
    assign sweeping = (state_q == ST_SWEEP);
    assign at_last  = sweeping && (cnt_q == LAST);
    assign acs_en   = enable && sweeping;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  ready = 1'b1;
            ST_SWEEP: ready = (cnt_q == LAST);
        endcase
    end

    assign accept = enable && load && ready;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (enable) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        state_d = ST_SWEEP;
                        cnt_d   = '0;
                    end
                end
                ST_SWEEP: begin
                    if (cnt_q == LAST) begin
                        state_d = load ? ST_SWEEP : ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + SW'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // ---------------- add-compare-select ----------------
    for (genvar x = 0; x < 2; x++) begin : g_branch
        vit_branch #(
            .N(N), .L(L), .SB(SB), .BMW(BMW), .TAPS(TAPS)
        ) u_br (
            .sym (sym_q),
            .win ({1'(x), cnt_q}),
            .bm  (bm[x])
        );
    end

    assign pred_a = {1'b0, cnt_q[SW-1:1]};
    assign pred_b = {1'b1, cnt_q[SW-1:1]};

    vit_metric_store #(.S(S), .SW(SW), .MW(MW)) u_pm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acs_en),
        .bank    (bank_q),
        .halve   (halve_q),
        .rd_a    (pred_a),
        .rd_b    (pred_b),
        .wr_addr (cnt_q),
        .wr_data (new_m),
        .m_a     (m_a),
        .m_b     (m_b)
    );

    assign sum_a     = {1'b0, m_a} + (MW+1)'(bm[0]);
    assign sum_b     = {1'b0, m_b} + (MW+1)'(bm[1]);
    assign pick      = (sum_b > sum_a);
    assign sel_sum   = pick ? sum_b : sum_a;
    assign new_m     = sel_sum[MW-1:0];
    assign better    = (cnt_q == '0) || (new_m > run_m_q);
    assign best_all  = better ? cnt_q : run_s_q;
    assign nflag_all = new_m[MW-1] | (nflag_q && (cnt_q != '0));

    // ---------------- traceback ----------------
    assign tb_load = acs_en && (cnt_q == '0);
    assign tb_step = acs_en && (cnt_q != '0) && (cnt_q <= TB_LAST);
    assign tb_col0 = (wcol_q == '0) ? CW'(D - 1) : wcol_q - CW'(1);

    vit_traceback #(.S(S), .SW(SW), .D(D), .CW(CW)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (acs_en),
        .wr_col    (wcol_q),
        .wr_state  (cnt_q),
        .wr_dec    (pick),
        .tb_load   (tb_load),
        .tb_col0   (tb_col0),
        .tb_state0 (best_q),
        .tb_step   (tb_step),
        .tb_bit    (tb_bit)
    );

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sym_q       <= '0;
            wcol_q      <= '0;
            bank_q      <= 1'b0;
            halve_q     <= 1'b0;
            nflag_q     <= 1'b0;
            done_q      <= '0;
            best_q      <= '0;
            run_s_q     <= '0;
            run_m_q     <= '0;
            decbits_q   <= '0;
            outvalid_q  <= 1'b0;
            normalize_q <= 1'b0;
        end else begin
            outvalid_q  <= 1'b0;
            normalize_q <= 1'b0;
            if (accept) begin
                sym_q <= rr;
            end
            if (acs_en) begin
                nflag_q <= nflag_all;
                if (better) begin
                    run_m_q <= new_m;
                    run_s_q <= cnt_q;
                end
                if (cnt_q == TB_OUT) begin
                    decbits_q  <= OUTW'(tb_bit);
                    outvalid_q <= (done_q == DW'(D));
                end
                if (at_last) begin
                    bank_q      <= ~bank_q;
                    wcol_q      <= (wcol_q == CW'(D - 1)) ? '0 : wcol_q + CW'(1);
                    halve_q     <= nflag_all;
                    normalize_q <= nflag_all;
                    best_q      <= best_all;
                    if (done_q != DW'(D)) begin
                        done_q <= done_q + DW'(1);
                    end
                end
            end
        end
    end

    assign decbits   = decbits_q;
    assign outvalid  = outvalid_q;
    assign normalize = normalize_q;

    AST_NORM_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        normalize |=> !normalize); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        acs_en |-> !sel_sum[MW]); // R3
    AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        outvalid |=> !outvalid); // R4
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ($stable(state_q) && $stable(cnt_q) && $stable(wcol_q))); // R7
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!outvalid && !normalize)); // R7

endmodule

// File: tb/vit_serial_decoder_tb.sv
module vit_serial_decoder_tb;

    localparam int N  = 2;
    localparam int L  = 7;
    localparam int SB = 3;
    localparam int V  = 35;
    localparam int S  = 1 << (L - 1);
    localparam logic [L-1:0] PA = 7'd91;
    localparam logic [L-1:0] PB = 7'd121;

    logic            clk = 1'b0;
    logic            rst;
    logic            enable;
    logic            load;
    logic [N*SB-1:0] rr;
    logic            ready;
    logic [0:0]      decbits;
    logic            outvalid;
    logic            normalize;

    vit_serial_decoder u_dut (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .load      (load),
        .rr        (rr),
        .ready     (ready),
        .decbits   (decbits),
        .outvalid  (outvalid),
        .normalize (normalize)
    );

    always #10 clk = ~clk;

    int      total = 0;
    int      bad = 0;
    int      loaded = 0;
    int      outputs = 0;
    int      normc = 0;
    longint  cyc = 0;
    longint  last_ov = 0;
    bit      have_last = 1'b0;
    bit      phase_a = 1'b0;
    bit      prev_norm = 1'b0;
    bit      en_edge = 1'b1;
    bit      expq[$];
    logic [L-1:0] sr = '0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        en_edge <= enable;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // monitor / scoreboard
    always begin
        @(negedge clk);
        #1;
        if (!rst) begin
            if (!en_edge) begin
                check(!outvalid && !normalize, "R7 pulse during stall", {outvalid, normalize}, 0);
            end
            if (normalize) begin
                normc++;
                check(!prev_norm, "R3 normalize width", 2, 1);
            end
            prev_norm = normalize;
            if (outvalid) begin
                if (outputs == 0) begin
                    check(loaded == V + 2, "R5 first output group", loaded, V + 2);
                end
                if (phase_a && have_last) begin
                    check(cyc - last_ov == S, "R4 output spacing", cyc - last_ov, S);
                end
                last_ov   = cyc;
                have_last = phase_a;
                if (expq.size() == 0) begin
                    check(1'b0, "R5 unexpected output", outputs, 0);
                end else begin
                    bit e;
                    e = expq.pop_front();
                    check(decbits[0] == e, "R1 R2 decoded bit", decbits[0], e);
                end
                outputs++;
            end
        end
    end

    // driver: encode one bit and present the group
    task automatic send_group(input bit b, input bit erase, input bit junk, input bit stall);
        bit c0, c1;
        logic [SB-1:0] s0, s1;
        sr = {sr[L-2:0], b};
        c0 = ^(sr & PA);
        c1 = ^(sr & PB);
        s0 = c0 ? 3'b101 : 3'b011;
        s1 = erase ? 3'b000 : (c1 ? 3'b101 : 3'b011);
        expq.push_back(b);
        while (!ready) @(negedge clk);
        rr   = {s0, s1};
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        rr   = N*SB'($urandom);
        loaded++;
        check(ready == 1'b0, "R6 ready low after take", ready, 0);
        if (junk) begin
            repeat (3) @(negedge clk);
            load = 1'b1;
            rr   = N*SB'($urandom);
            @(negedge clk);
            load = 1'b0;
        end
        if (stall) begin
            repeat (30) @(negedge clk);
            enable = 1'b0;
            repeat (30) @(negedge clk);
            enable = 1'b1;
        end
    endtask

    initial begin
        rst    = 1'b1;
        enable = 1'b1;
        load   = 1'b0;
        rr     = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1, "R8 ready after reset", ready, 1);
        check(outvalid == 1'b0, "R8 outvalid after reset", outvalid, 0);
        check(normalize == 1'b0, "R8 normalize after reset", normalize, 0);
        check(decbits == 1'b0, "R8 decbits after reset", decbits, 0);

        // phase A: back-to-back groups
        phase_a = 1'b1;
        for (int g = 0; g < 150; g++) send_group(1'($urandom_range(0, 1)), 1'b0, 1'b0, 1'b0);
        phase_a = 1'b0;

        // phase B: idle gaps, stalls, ignored loads
        for (int g = 0; g < 150; g++) begin
            send_group(1'($urandom_range(0, 1)), 1'b0, (g % 7) == 3, (g % 5) == 1);
            while (!ready) @(negedge clk);
            for (int k = 0; k < (g % 4); k++) begin
                @(negedge clk);
                check(ready == 1'b1, "R6 ready high while idle", ready, 1);
            end
        end

        // phase C: erased symbols
        for (int g = 0; g < 500; g++) send_group(1'($urandom_range(0, 1)), (g % 3) == 2, 1'b0, 1'b0);

        while (!ready) @(negedge clk);
        repeat (S + 4) @(negedge clk);
        check(outputs == loaded - V - 1, "R5 output count", outputs, loaded - V - 1);
        check(expq.size() == V + 1, "R5 pending bits", expq.size(), V + 1);
        check(normc >= 1, "R3 normalize seen", normc, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule